// File: doc/BRIEF.md
# DisplayPort Link Rate and Lane Selector

This block picks a link configuration for a display stream. A single start pulse delivers the pixel clock in kHz, the colour depth in bits per colour, and the sink's limits: its highest link rate in kHz, its highest lane count, and whether it supports DP1.2. The block also takes a flag that selects bridge operation. It then walks the candidate (rate, lane count) pairs one per clock. The first pair whose bandwidth covers the stream is chosen.

The fit test multiplies both sides and never divides. It compares `lanes * rate * 8` against `pixClk * bpp`, which gives the same answer as truncating division. When the search ends, a one-cycle `done` pulse is raised, and the lane count, the rate, a failure flag and a mode-valid flag are reported together. These results hold until the next search completes. Reading the sink capabilities from the sink is handled elsewhere and is not part of this block.

Top module: `link_cfg_search`

## Requirements
- R1: Bits per pixel is 24 when `bpc` is 0 and `3 * bpc` otherwise.
- R2: Outside bridge mode, rates are tried lowest first in the order 162000, 270000, 540000 kHz. A rate above `sinkMaxRate` ends the search.
- R3: Within each rate, lane counts 1, 2 and 4 are tried in rising order. A lane count above `sinkMaxLanes` ends that rate. `laneCount` is 1, 2 or 4 in binary, or 0.
- R4: A candidate fits when `lanes * rate * 8 >= pixClk * bpp`. The first fitting candidate in search order is reported, and equality counts as a fit.
- R5: In bridge mode only 270000 kHz is tried, and `sinkMaxRate` is ignored. Lane counts are searched as in R3.
- R6: When no candidate fits, `fail` is 1 and both `laneCount` and `rateKhz` are 0.
- R7: `modeValid` is 0 whenever `fail` is 1.
- R8: A fit at 540000 kHz with `sinkDp12` low still reports its lanes and rate with `fail` 0, but `modeValid` is 0. Every other fit gives `modeValid` 1.
- R9: Each accepted start gives exactly one one-cycle `done` pulse. The start is accepted at clock edge k. Candidate n (counting from 1) is evaluated at edge k+n, and `done` and the results appear at the edge that evaluates the last candidate visited.
- R10: A start that arrives while a search is running is ignored: it neither changes that search's result nor adds a `done` pulse. Results hold between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search with the operands below (accepted when idle) |
| pixClk | input | PIX_W | Pixel clock in kHz |
| bpc | input | BPC_W | Bits per colour, 0 means default |
| sinkMaxRate | input | 20 | Highest link rate of the sink, kHz |
| sinkMaxLanes | input | LANE_W | Highest lane count of the sink |
| bridgeMode | input | 1 | Restrict the search to 270000 kHz |
| sinkDp12 | input | 1 | Sink supports DP1.2 |
| done | output | 1 | One-cycle pulse when the results are ready |
| laneCount | output | LANE_W | Chosen lane count (0 on failure) |
| rateKhz | output | 20 | Chosen link rate in kHz (0 on failure) |
| fail | output | 1 | No configuration fits |
| modeValid | output | 1 | The mode can be driven |

## Verification
A search that visits n candidates raises `done` n edges after the edge that accepts the start. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the start edge and expects `done` on count n+1: count 2 when the first candidate fits, and count 10 for a search that tries all nine candidates and fails. Results are read in the same falling-edge window as `done`. Two more windows are then checked to confirm the pulse is single. For random operands the bench does not compute the exact latency, so it waits up to a fixed bound and checks only the results.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int RATE_W          = 20;
  localparam int NUM_RATES       = 3;
  localparam int RIDX_W          = $clog2(NUM_RATES);
  localparam int BRIDGE_RATE_IDX = 1;
  localparam int TOP_RATE_IDX    = NUM_RATES - 1;

  typedef enum logic {ST_IDLE, ST_SEARCH} lcsState_e;
  typedef enum logic [1:0] {OUT_NEXT, OUT_HIT, OUT_MISS} lcsOutcome_e;

  typedef struct packed {
    logic load;
    logic eval;
  } lcsStrobe_t;

  function automatic logic [RATE_W-1:0] rateOf(input logic [RIDX_W-1:0] idx);
    case (idx)
      RIDX_W'(0): rateOf = RATE_W'(162000);
      RIDX_W'(1): rateOf = RATE_W'(270000);
      default:    rateOf = RATE_W'(540000);
    endcase
  endfunction
endpackage

// File: rtl/lcs_datapath.sv
module lcs_datapath
  import lcs_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int BPC_W  = 4,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcsStrobe_t        strobe,
  input  logic [PIX_W-1:0]  pixClk,
  input  logic [BPC_W-1:0]  bpc,
  input  logic [RATE_W-1:0] sinkMaxRate,
  input  logic [LANE_W-1:0] sinkMaxLanes,
  input  logic              bridgeMode,
  input  logic              sinkDp12,
  output lcsOutcome_e       outcome,
  output logic [LANE_W-1:0] lanesOut,
  output logic [RATE_W-1:0] rateOut,
  output logic              failOut,
  output logic              modeValidOut
);
  localparam int BPP_W  = (BPC_W + 2 > 5) ? BPC_W + 2 : 5;
  localparam int LIDX_W = (LANE_W > 1) ? $clog2(LANE_W) : 1;
  localparam int LAST_L = LANE_W - 1;
  localparam int CAP_W  = LANE_W + RATE_W + 3;
  localparam int DEM_W  = PIX_W + BPP_W;
  localparam int PROD_W = (CAP_W > DEM_W) ? CAP_W : DEM_W;

  logic [PIX_W-1:0]  pixQ;
  logic [BPP_W-1:0]  bppQ;
  logic [RATE_W-1:0] maxRateQ;
  logic [LANE_W-1:0] maxLanesQ;
  logic              bridgeQ;
  logic              dp12Q;
  logic [RIDX_W-1:0] rIdx;
  logic [LIDX_W-1:0] lIdx;

  logic [RATE_W-1:0] candRate;
  logic [LANE_W-1:0] candLanes;
  logic [PROD_W-1:0] capacity;
  logic [PROD_W-1:0] demand;
  logic              rateOk, laneOk, lastRate, advRate, advLane;
  logic [BPP_W-1:0]  bppIn;

  // bits per pixel from bits per colour (R1)
  assign bppIn = (bpc == '0) ? BPP_W'(24) : BPP_W'(bpc) * BPP_W'(3);

  assign candRate  = rateOf(rIdx);
  assign candLanes = LANE_W'(1) << lIdx;
  assign rateOk    = bridgeQ || (candRate <= maxRateQ);
  assign laneOk    = candLanes <= maxLanesQ;
  assign lastRate  = bridgeQ || (rIdx == RIDX_W'(NUM_RATES - 1));
  assign capacity  = PROD_W'(candLanes) * PROD_W'(candRate) * PROD_W'(8);
  assign demand    = PROD_W'(pixQ) * PROD_W'(bppQ);

  // candidate outcome: rates outer, lanes inner, both ascending (R2, R3, R4)
  always_comb begin
    outcome = OUT_NEXT;
    advRate = 1'b0;
    advLane = 1'b0;
    if (!rateOk) begin
      outcome = OUT_MISS;
    end else if (!laneOk) begin
      if (lIdx == '0 || lastRate) outcome = OUT_MISS;
      else                        advRate = 1'b1;
    end else if (capacity >= demand) begin
      outcome = OUT_HIT;
    end else if (lIdx == LIDX_W'(LAST_L)) begin
      if (lastRate) outcome = OUT_MISS;
      else          advRate = 1'b1;
    end else begin
      advLane = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixQ      <= '0;
      bppQ      <= '0;
      maxRateQ  <= '0;
      maxLanesQ <= '0;
      bridgeQ   <= 1'b0;
      dp12Q     <= 1'b0;
      rIdx      <= '0;
      lIdx      <= '0;
    end else if (strobe.load) begin
      pixQ      <= pixClk;
      bppQ      <= bppIn;
      maxRateQ  <= sinkMaxRate;
      maxLanesQ <= sinkMaxLanes;
      bridgeQ   <= bridgeMode;
      dp12Q     <= sinkDp12;
      // bridge mode searches the single middle rate only (R5)
      rIdx      <= bridgeMode ? RIDX_W'(BRIDGE_RATE_IDX) : '0;
      lIdx      <= '0;
    end else if (strobe.eval) begin
      if (advRate) begin
        rIdx <= rIdx + RIDX_W'(1);
        lIdx <= '0;
      end else if (advLane) begin
        lIdx <= lIdx + LIDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lanesOut     <= '0;
      rateOut      <= '0;
      failOut      <= 1'b0;
      modeValidOut <= 1'b0;
    end else if (strobe.eval && outcome == OUT_HIT) begin
      lanesOut     <= candLanes;
      rateOut      <= candRate;
      failOut      <= 1'b0;
      modeValidOut <= !(rIdx == RIDX_W'(TOP_RATE_IDX) && !dp12Q);
    end else if (strobe.eval && outcome == OUT_MISS) begin
      lanesOut     <= '0;
      rateOut      <= '0;
      failOut      <= 1'b1;
      modeValidOut <= 1'b0;
    end
  end

  a_r6_fail_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    failOut |-> (lanesOut == '0 && rateOut == '0));

  a_r7_fail_invalid: assert property (@(posedge clk) disable iff (!rstN)
    failOut |-> !modeValidOut);

  a_r8_top_rate_gate: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eval && outcome == OUT_HIT && rIdx == RIDX_W'(TOP_RATE_IDX) && !dp12Q)
      |=> (!modeValidOut && !failOut));

  a_r3_lane_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lanesOut));

  a_r5_bridge_rate: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eval && outcome != OUT_NEXT && bridgeQ)
      |=> (failOut || rateOut == rateOf(RIDX_W'(BRIDGE_RATE_IDX))));

  a_r4_fit_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eval && outcome == OUT_HIT)
      |=> (PROD_W'(lanesOut) * PROD_W'(rateOut) * PROD_W'(8) >= demand));
endmodule

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
  import lcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  lcsOutcome_e outcome,
  output lcsStrobe_t  strobe,
  output logic        done
);
  lcsState_e state;

  // a start is taken only while idle (R10)
  assign strobe.load = (state == ST_IDLE) && start;
  assign strobe.eval = (state == ST_SEARCH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:   if (start) state <= ST_SEARCH;
        ST_SEARCH: if (outcome != OUT_NEXT) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  a_r9_single_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEARCH && outcome == OUT_NEXT) |=> (state == ST_SEARCH && !done));
endmodule

// File: rtl/link_cfg_search.sv
module link_cfg_search
  import lcs_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int BPC_W  = 4,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PIX_W-1:0]  pixClk,
  input  logic [BPC_W-1:0]  bpc,
  input  logic [RATE_W-1:0] sinkMaxRate,
  input  logic [LANE_W-1:0] sinkMaxLanes,
  input  logic              bridgeMode,
  input  logic              sinkDp12,
  output logic              done,
  output logic [LANE_W-1:0] laneCount,
  output logic [RATE_W-1:0] rateKhz,
  output logic              fail,
  output logic              modeValid
);
  lcsStrobe_t  strobe;
  lcsOutcome_e outcome;

  lcs_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .outcome (outcome),
    .strobe  (strobe),
    .done    (done)
  );

  lcs_datapath #(
    .PIX_W  (PIX_W),
    .BPC_W  (BPC_W),
    .LANE_W (LANE_W)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .pixClk       (pixClk),
    .bpc          (bpc),
    .sinkMaxRate  (sinkMaxRate),
    .sinkMaxLanes (sinkMaxLanes),
    .bridgeMode   (bridgeMode),
    .sinkDp12     (sinkDp12),
    .outcome      (outcome),
    .lanesOut     (laneCount),
    .rateOut      (rateKhz),
    .failOut      (fail),
    .modeValidOut (modeValid)
  );
endmodule

// File: tb/link_cfg_search_test.sv
module link_cfg_search_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pixClk = '0;
  logic [3:0]  bpc = '0;
  logic [19:0] sinkMaxRate = '0;
  logic [2:0]  sinkMaxLanes = '0;
  logic        bridgeMode = 1'b0;
  logic        sinkDp12 = 1'b0;
  logic        done;
  logic [2:0]  laneCount;
  logic [19:0] rateKhz;
  logic        fail;
  logic        modeValid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  link_cfg_search uut (
    .clk(clk), .rstN(rstN), .start(start), .pixClk(pixClk), .bpc(bpc),
    .sinkMaxRate(sinkMaxRate), .sinkMaxLanes(sinkMaxLanes),
    .bridgeMode(bridgeMode), .sinkDp12(sinkDp12), .done(done),
    .laneCount(laneCount), .rateKhz(rateKhz), .fail(fail), .modeValid(modeValid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference search written from the requirements
  task automatic model(input longint pix, input int bc, input longint maxRate,
                       input int maxLanes, input bit bridge, input bit dp12,
                       output longint eLanes, output longint eRate,
                       output bit eFail, output bit eValid);
    longint rates[3] = '{162000, 270000, 540000};
    longint bpp = (bc == 0) ? 24 : 3 * bc;
    bit found = 0;
    eLanes = 0; eRate = 0;
    for (int i = 0; i < 3 && !found; i++) begin
      if (bridge && i != 1) continue;
      if (!bridge && rates[i] > maxRate) break;
      for (int l = 1; l <= maxLanes && l <= 4 && !found; l = l * 2) begin
        if ((l * rates[i] * 8) / bpp >= pix) begin
          found = 1; eLanes = l; eRate = rates[i];
        end
      end
    end
    eFail = !found;
    eValid = found && !(eRate == 540000 && !dp12);
  endtask

  task automatic run(input string tag, input longint pix, input int bc,
                     input longint maxRate, input int maxLanes, input bit bridge,
                     input bit dp12, input int expLat, input int injectAt);
    longint eL, eR;
    bit eF, eV;
    int cnt = 0;
    int extra = 0;
    model(pix, bc, maxRate, maxLanes, bridge, dp12, eL, eR, eF, eV);
    @(negedge clk);
    pixClk = pix[19:0]; bpc = bc[3:0]; sinkMaxRate = maxRate[19:0];
    sinkMaxLanes = maxLanes[2:0]; bridgeMode = bridge; sinkDp12 = dp12;
    start = 1'b1;
    while (cnt < 30) begin
      @(negedge clk);
      cnt++;
      start = 1'b0;
      if (done) break;
      if (cnt == injectAt) begin
        start = 1'b1; pixClk = 20'd1; bpc = 4'd1; bridgeMode = 1'b0;
        sinkMaxRate = 20'd540000; sinkMaxLanes = 3'd4;
      end
    end
    check({tag, " R9 done seen"}, done, 1);
    if (expLat > 0) check({tag, " R9 latency"}, cnt, expLat);
    check({tag, " R4 lanes"}, laneCount, eL);
    check({tag, " R4 rate"}, rateKhz, eR);
    check({tag, " R6 fail"}, fail, eF);
    check({tag, " R8 modeValid"}, modeValid, eV);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check({tag, " R9 single pulse"}, extra, 0);
    check({tag, " R10 results hold"}, rateKhz, eR);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R9 reset done", done, 0);
    check("R6 reset lanes", laneCount, 0);
    check("R6 reset rate", rateKhz, 0);
    check("R7 reset fail/valid", {fail, modeValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4/R9: first candidate fits, exact equality boundary
    run("eq", 54000, 8, 540000, 4, 0, 1, 2, 0);
    run("eq+1", 54001, 8, 540000, 4, 0, 1, 3, 0);
    run("first", 1, 0, 540000, 4, 0, 0, 2, 0);
    // R1: bpc 0 equals bpc 8; bpc 10 needs more lanes
    run("bpc0", 100000, 0, 540000, 4, 0, 1, 3, 0);
    run("bpc8", 100000, 8, 540000, 4, 0, 1, 3, 0);
    run("bpc10", 100000, 10, 540000, 4, 0, 1, 4, 0);
    // R2: rates above sink maximum skipped, and none allowed
    run("cap270", 400000, 8, 270000, 4, 0, 1, -1, 0);
    run("norate", 1, 8, 150000, 4, 0, 1, 2, 0);
    // R3: lane limit 2 pushes to a higher rate; zero lanes fails
    run("lane2", 100000, 10, 540000, 2, 0, 1, -1, 0);
    run("lane0", 1, 8, 540000, 0, 0, 1, 2, 0);
    // R8: top rate gated on DP1.2
    run("top_nodp12", 500000, 8, 540000, 4, 0, 0, -1, 0);
    run("top_dp12", 500000, 8, 540000, 4, 0, 1, -1, 0);
    // R5: bridge ignores sink maximum rate, one rate only
    run("bridge", 100000, 8, 100000, 4, 1, 0, 3, 0);
    run("bridge_fail", 500000, 8, 540000, 4, 1, 1, 4, 0);
    // R6/R9: full sweep of nine candidates then failure
    run("sweep", 1000000, 15, 540000, 4, 0, 1, 10, 0);
    // R10: start while busy ignored
    run("busy", 1000000, 15, 540000, 4, 0, 1, 10, 3);

    for (int n = 0; n < 300; n++) begin
      longint mr;
      case ($urandom % 6)
        0: mr = 100000;
        1: mr = 162000;
        2: mr = 270000;
        3: mr = 540000;
        4: mr = 300000;
        default: mr = $urandom % 1048576;
      endcase
      run("rand", $urandom % 800001, int'($urandom % 16), mr,
          int'($urandom % 8), ($urandom % 4) == 0, $urandom % 2, -1, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule